// File: doc/BRIEF.md
# Cascaded Eight-Channel DMA Arbiter with Address Formation

This block merges two four-channel DMA request units into a single eight-channel arbiter. Channels 0 to 3 form the lower unit and move one byte per transfer. Channels 4 to 7 form the upper unit and move one 16-bit word per transfer. Slot 4 of the upper unit has no device. It serves only as the cascade input for the whole lower unit, so every lower channel outranks every upper one.

Each channel has an 8-bit page register, a 16-bit current-address counter and a 16-bit remaining-count register, all loaded through a simple write port. On every `step_i` pulse (one transfer step of the DMA clock) the block picks one winner. It presents the winner's 24-bit memory address, a word/byte flag and a terminal-count pulse. It then advances that channel's address and count. A channel whose count wraps from zero is masked until its count is written again.

Top module: `dma_cascade_arb`

## Requirements
- R1: After reset `gnt_o`, `tc_o`, `word_o` and `addr_o` are zero and every channel is masked, so no request is granted until that channel's count is written.
- R2: Within each unit the lowest-numbered unmasked requesting channel wins.
- R3: Any unmasked request on channels 0 to 3 wins over every request on channels 5 to 7.
- R4: `req_i[4]` has no effect on arbitration, and `gnt_o[4]` is never asserted.
- R5: A grant appears on `gnt_o` in the cycle after a cycle with `step_i` high, is one-hot, and lasts exactly one cycle. No grant appears after a cycle with `step_i` low.
- R6: For a granted channel 0 to 3, `addr_o` = {page[7:0], counter[15:0]} and `word_o` = 0.
- R7: For a granted channel 5 to 7, `addr_o` = {page[7:1], counter[15:0], 1'b0}, which is always even, and `word_o` = 1.
- R8: Each grant uses the counter value before the step, then increments that channel's address counter by one and decrements its count by one, both modulo 2^16.
- R9: A grant taken while the channel's count is zero pulses `tc_o[ch]` together with `gnt_o[ch]` and masks the channel. Writing the count clears the mask.
- R10: Arbitration is re-evaluated on every step, so a higher-priority request that appears mid-block takes the next step.
- R11: Writes select a register with `wr_sel_i`: 0 page, 1 address counter, 2 count. Code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Transfer-step enable pulse |
| req_i | input | 8 | Per-channel service requests |
| wr_en_i | input | 1 | Register write strobe |
| wr_chan_i | input | 3 | Channel addressed by the write |
| wr_sel_i | input | 2 | Register select: 0 page, 1 address, 2 count, 3 none |
| wr_data_i | input | 16 | Write data (page uses bits 7:0) |
| gnt_o | output | 8 | One-hot grant, one cycle per step |
| addr_o | output | 24 | Memory address of the granted transfer |
| word_o | output | 1 | High for a 16-bit word transfer |
| tc_o | output | 8 | Terminal-count pulse per channel |

## Verification
A corrupted address counter shows up on `addr_o` at the very next grant of that channel. A wrong count or mask shows up as a misplaced `tc_o` pulse, or as a grant to a channel that should be masked, within the count's remaining steps. A priority or cascade fault shows up on the next step in which channels of both units request. The random phase keeps counts small so that terminal counts and re-enables happen often, and the bench model tracks every register so the first wrong step is reported.

// File: rtl/dma_cas_pkg.sv
package dma_cas_pkg;
  localparam int unsigned UNIT_CH = 4;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned PAGE_W  = 8;

  typedef enum logic [1:0] {
    SEL_PAGE  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/dma_fixed_prio.sv
module dma_fixed_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan_state.sv
module dma_chan_state
  import dma_cas_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned PW = PAGE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          adv_i,
  output logic [PW-1:0] page_o,
  output logic [CW-1:0] addr_o,
  output logic          mask_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      addr_o <= '0;
      cnt_q  <= '0;
      mask_o <= 1'b1;
    end else if (wr_en_i) begin
      case (wr_sel_e'(wr_sel_i))
        SEL_PAGE:  page_o <= wr_data_i[PW-1:0];
        SEL_ADDR:  addr_o <= wr_data_i;
        SEL_COUNT: begin
          cnt_q  <= wr_data_i;
          mask_o <= 1'b0;
        end
        default: ;
      endcase
    end else if (adv_i) begin
      addr_o <= addr_o + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == '0) mask_o <= 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  p_tc_masks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && zero_o) |=> mask_o);
  p_addr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i) |=> (addr_o == CW'($past(addr_o) + 1'b1)));
endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb
  import dma_cas_pkg::*;
#(
  parameter int unsigned UC = UNIT_CH,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned PW = PAGE_W,
  localparam int unsigned NC   = 2 * UC,
  localparam int unsigned AW   = CW + PW,
  localparam int unsigned CH_W = $clog2(NC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [NC-1:0]   req_i,
  input  logic            wr_en_i,
  input  logic [CH_W-1:0] wr_chan_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [CW-1:0]   wr_data_i,
  output logic [NC-1:0]   gnt_o,
  output logic [AW-1:0]   addr_o,
  output logic            word_o,
  output logic [NC-1:0]   tc_o
);
  logic [PW-1:0] page_w [NC];
  logic [CW-1:0] cur_w  [NC];
  logic [AW-1:0] ch_addr [NC];
  logic [NC-1:0] mask_w, zero_w, win;

  for (genvar gi = 0; gi < int'(NC); gi++) begin : g_ch
    dma_chan_state #(.CW(CW), .PW(PW)) u_st (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i && (wr_chan_i == CH_W'(gi))),
      .wr_sel_i (wr_sel_i),
      .wr_data_i(wr_data_i),
      .adv_i    (step_i && win[gi]),
      .page_o   (page_w[gi]),
      .addr_o   (cur_w[gi]),
      .mask_o   (mask_w[gi]),
      .zero_o   (zero_w[gi])
    );
    if (gi >= int'(UC)) begin : g_word
      assign ch_addr[gi] = {page_w[gi][PW-1:1], cur_w[gi], 1'b0};
    end else begin : g_byte
      assign ch_addr[gi] = {page_w[gi], cur_w[gi]};
    end
  end

  // Lower unit feeds the cascade slot; external slot request is dropped.
  logic [UC-1:0] eff_lo, gnt_lo, hi_req, gnt_hi;
  logic          casc;
  assign eff_lo = req_i[UC-1:0] & ~mask_w[UC-1:0];
  assign casc   = |eff_lo;
  assign hi_req = {req_i[NC-1:UC+1] & ~mask_w[NC-1:UC+1], casc};

  dma_fixed_prio #(.N(UC)) u_lo (.req_i(eff_lo), .gnt_o(gnt_lo));
  dma_fixed_prio #(.N(UC)) u_hi (.req_i(hi_req), .gnt_o(gnt_hi));

  assign win = casc ? {{UC{1'b0}}, gnt_lo}
                    : {gnt_hi[UC-1:1], 1'b0, {UC{1'b0}}};

  logic unused_casc;
  assign unused_casc = ^{req_i[UC], mask_w[UC], gnt_hi[0]};

  logic [AW-1:0] sel_addr;
  logic [NC-1:0] sel_tc;
  always_comb begin
    sel_addr = '0;
    for (int i = 0; i < int'(NC); i++) begin
      if (win[i]) sel_addr = sel_addr | ch_addr[i];
    end
    sel_tc = win & zero_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o  <= '0;
      addr_o <= '0;
      word_o <= 1'b0;
      tc_o   <= '0;
    end else if (step_i && |win) begin
      gnt_o  <= win;
      addr_o <= sel_addr;
      word_o <= |win[NC-1:UC];
      tc_o   <= sel_tc;
    end else begin
      gnt_o  <= '0;
      addr_o <= '0;
      word_o <= 1'b0;
      tc_o   <= '0;
    end
  end

  p_gnt_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> $onehot(gnt_o));
  p_gnt_after_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> $past(step_i));
  p_casc_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_o[UC]);
  p_lo_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o[NC-1:UC+1]) |-> !$past(casc));
  p_word_even_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o |-> !addr_o[0]);
  p_tc_with_gnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o & ~gnt_o) == '0);
endmodule

// File: tb/sim_dma_cascade_arb.sv
module sim_dma_cascade_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [7:0]  req = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_chan = '0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  gnt, tc;
  logic [23:0] addr;
  logic        word;

  int checks = 0;
  int errors = 0;

  logic [7:0]  pg [8];
  logic [15:0] ad [8];
  logic [15:0] ct [8];
  bit          mk [8];

  always #5 clk = ~clk;

  dma_cascade_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .req_i(req),
    .wr_en_i(wr_en), .wr_chan_i(wr_chan), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .gnt_o(gnt), .addr_o(addr), .word_o(word), .tc_o(tc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int winner(input logic [7:0] r);
    for (int i = 0; i < 4; i++) if (r[i] && !mk[i]) return i;
    for (int i = 5; i < 8; i++) if (r[i] && !mk[i]) return i;
    return -1;
  endfunction

  function automatic logic [23:0] form_addr(input int ch);
    if (ch >= 4) return {pg[ch][7:1], ad[ch], 1'b0};
    return {pg[ch], ad[ch]};
  endfunction

  task automatic wr(input int ch, input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 3'(ch); wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: pg[ch] = d[7:0];
      2'd1: ad[ch] = d;
      2'd2: begin ct[ch] = d; mk[ch] = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic do_step(input logic [7:0] r, input string tag);
    int w;
    logic [7:0] eg, et;
    logic [23:0] ea;
    @(negedge clk);
    req = r; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    w = winner(r);
    eg = '0; et = '0; ea = '0;
    if (w >= 0) begin
      eg[w] = 1'b1;
      ea = form_addr(w);
      if (ct[w] == 16'h0) begin et[w] = 1'b1; mk[w] = 1'b1; end
      ad[w] = ad[w] + 16'h1;
      ct[w] = ct[w] - 16'h1;
    end
    chk(gnt == eg, tag, 32'(gnt), 32'(eg));
    chk(addr == ea, (w >= 4) ? "R7 addr" : "R6/R8 addr", 32'(addr), 32'(ea));
    chk(word == (w >= 4), (w >= 4) ? "R7 word" : "R6 word", 32'(word), 32'(w >= 4));
    chk(tc == et, "R9 tc", 32'(tc), 32'(et));
  endtask

  task automatic idle_chk(input string tag);
    @(negedge clk);
    chk(gnt == 8'h0 && tc == 8'h0, tag, 32'({gnt, tc}), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin
      pg[i] = '0; ad[i] = '0; ct[i] = '0; mk[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    chk(gnt == 0 && tc == 0 && addr == 0 && word == 0, "R1 reset outputs", 32'(addr), 32'h0);
    rst_n = 1'b1;
    do_step(8'hFF, "R1 all masked");

    for (int i = 0; i < 8; i++) begin
      wr(i, 2'd0, 16'(8'h31 + 8'(i * 16)));
      wr(i, 2'd1, 16'(16'h8001 + 16'(i * 16'h111)));
      wr(i, 2'd2, 16'd20);
    end
    wr(3, 2'd3, 16'hFFFF); // R11 code 3 leaves state alone

    do_step(8'h10, "R4 cascade input alone");
    do_step(8'h30, "R4 cascade input with ch5");
    do_step(8'hFF, "R3 all requesting");
    do_step(8'hE6, "R2 lowest in lower unit");
    do_step(8'hE8, "R3 lower unit beats upper");
    do_step(8'hC0, "R2 lowest in upper unit");
    do_step(8'h08, "R11 ch3 untouched by code 3");

    // R5: no step, no grant; grant lasts one cycle
    @(negedge clk); req = 8'hFF;
    idle_chk("R5 no grant without step");
    do_step(8'h02, "R5 single grant");
    idle_chk("R5 grant lasts one cycle");

    // R9 terminal count
    wr(2, 2'd2, 16'd1);
    do_step(8'h04, "R9 count one");
    do_step(8'h04, "R9 count zero gives tc");
    do_step(8'h04, "R9 masked after tc");
    wr(2, 2'd2, 16'd0);
    do_step(8'h04, "R9 count write unmasks");

    // R10 re-arbitration mid-block
    do_step(8'h40, "R10 ch6 alone");
    do_step(8'h60, "R10 ch5 arrives");
    do_step(8'h42, "R10 ch1 arrives");
    do_step(8'h40, "R10 back to ch6");

    // R7/R8 counter wrap on a word channel
    wr(7, 2'd1, 16'hFFFF);
    do_step(8'h80, "R8 counter at top");
    do_step(8'h80, "R8 counter wrapped");

    for (int n = 0; n < 600; n++) begin
      if (($urandom % 6) == 0) begin
        int c;
        logic [1:0] s;
        c = int'($urandom % 8);
        s = 2'($urandom % 4);
        wr(c, s, (s == 2'd2) ? 16'($urandom % 5) : 16'($urandom));
      end
      do_step(8'($urandom), "R2/R3/R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule